// File: doc/BRIEF.md
# Two-Level Connection Translation Lookup

This block is the connection lookup engine of one switch input port. A cell header arrives with its path identifier, its channel identifier, its loss-priority bit, its source trunk group, and a flag that tells whether it came from the external link or from the recycling path. The engine reads a single-port table of `ENTRIES` route words. A bound register splits the table. Entries below the bound form the path section, indexed by the path identifier. Entries from the bound upward form the channel section, indexed by bound plus channel identifier. The engine returns the routing data for two copies of the cell: two output ports, two replacement identifier pairs, and two forward/recycle selects. It also returns the per-connection flags and a source trunk group.

Every route word has a 32-bit cell counter beside it, held in its own memory. The counter is updated read-modify-write when a lookup ends without error. A host port reads and writes route words together with their counters, and it also loads the bound. The host port is served only while no lookup is in flight. Lookups have a fixed latency, so a surrounding pipeline can schedule around them.

Top module: `vxlt_lookup`

## Requirements
- R1: After reset, `req_ready` and `host_ready` are 1, `res_valid`, `res_err` and `host_rvalid` are 0, and the bound is 256.
- R2: When the path entry has its terminate bit at 0, the result pulses on `res_valid` or `res_err` exactly 3 clock edges after the edge that accepted the request.
- R3: When the path entry has its terminate bit at 1, a second read at table address bound+channel-id supplies the result, and the pulse comes exactly 5 edges after acceptance.
- R4: Route word layout, from MSB to LSB: busy, set_clp, terminate, recycle_only, upstream_discard, continuous, discard_index[3:0], recycle1, recycle0, port1[5:0], port0[5:0], vpi1[7:0], vpi0[7:0], vci1[15:0], vci0[15:0] (72 bits). A good result copies every routing field of the selected entry to the matching `res_*` output.
- R5: `res_clp` is 1 when the entry's set_clp is 1. Otherwise it equals the incoming `req_clp`.
- R6: `res_stg` equals `port_id` for link cells and `req_stg` for recycled cells.
- R7: If the selected entry has busy at 0, the cell is dropped: `res_err` pulses with code 1 and `res_valid` stays 0.
- R8: A link cell that selects a recycle_only entry is dropped with error code 2. A recycled cell that selects the same entry is forwarded.
- R9: A path identifier at or above the bound, or a channel address bound+channel-id above `ENTRIES-1`, drops the cell with error code 3. Address `ENTRIES-1` itself is valid.
- R10: Each good cell adds 1 (modulo 2^32) to the counter of its selected entry. Dropped cells leave every counter unchanged. Host op 0 (read) returns the word and counter on `host_rvalid`, and host op 1 (write) stores both.
- R11: While a lookup is in flight, `req_ready` and `host_ready` are 0.
- R12: Host op 2 loads `host_addr` into the bound, and later channel lookups use the new base.
- R13: `res_valid` and `res_err` are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_id | input | PORT_W | Number of this switch port |
| req_valid | input | 1 | Cell header present |
| req_ready | output | 1 | Engine idle, header accepted |
| req_vpi | input | VPI_W | Path identifier |
| req_vci | input | VCI_W | Channel identifier |
| req_clp | input | 1 | Incoming loss-priority bit |
| req_from_rcy | input | 1 | 1 = cell came from the recycling path |
| req_stg | input | PORT_W | Source trunk group carried by a recycled cell |
| host_valid | input | 1 | Host operation present |
| host_ready | output | 1 | Host operation accepted this cycle |
| host_op | input | 2 | 0 read, 1 write, 2 load bound |
| host_addr | input | AW | Entry address or bound value |
| host_wentry | input | ENTRY_W | Route word to write |
| host_wcnt | input | CNT_W | Counter value to write |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rentry | output | ENTRY_W | Route word read |
| host_rcnt | output | CNT_W | Counter read |
| res_valid | output | 1 | Good result pulse |
| res_err | output | 1 | Dropped-cell pulse |
| res_err_code | output | 2 | 1 idle, 2 recycle-only, 3 range |
| res_port0 | output | PORT_W | First copy output port |
| res_port1 | output | PORT_W | Second copy output port |
| res_vpi0 | output | VPI_W | First copy new path id |
| res_vpi1 | output | VPI_W | Second copy new path id |
| res_vci0 | output | VCI_W | First copy new channel id |
| res_vci1 | output | VCI_W | Second copy new channel id |
| res_rcy0 | output | 1 | First copy recycle select |
| res_rcy1 | output | 1 | Second copy recycle select |
| res_clp | output | 1 | Outgoing loss-priority bit |
| res_stg | output | PORT_W | Source trunk group |
| res_updisc | output | 1 | Upstream discard flag |
| res_cstream | output | 1 | Continuous-stream flag |
| res_bdi | output | BDI_W | Block discard index |

## Verification
The lookup is exercised with four header patterns: a direct path hit, a terminating path that chains into the channel section, headers that land on idle, recycle-only or out-of-range entries, and the same identifiers again after the bound moves. The first two patterns separate the 3-cycle and 5-cycle paths, and they show whether the result fields come from the right one of the two words read. The error patterns show whether each drop reason gets its own code and leaves the counters alone. The boundary channel addresses (last entry against one past it) and a counter preset to all ones pin down the off-by-one and wrap cases. Moving the bound shows that the channel base really follows the register.

// File: rtl/vxlt_pkg.sv
package vxlt_pkg;
  localparam int PORT_W = 6;
  localparam int VPI_W  = 8;
  localparam int VCI_W  = 16;
  localparam int BDI_W  = 4;

  typedef struct packed {
    logic             busy;
    logic             set_clp;
    logic             vp_term;
    logic             rcy_only;
    logic             updisc;
    logic             cstream;
    logic [BDI_W-1:0] bdi;
    logic             rcy1;
    logic             rcy0;
    logic [PORT_W-1:0] port1;
    logic [PORT_W-1:0] port0;
    logic [VPI_W-1:0] vpi1;
    logic [VPI_W-1:0] vpi0;
    logic [VCI_W-1:0] vci1;
    logic [VCI_W-1:0] vci0;
  } entry_t;

  typedef struct packed {
    logic             set_clp;
    logic             updisc;
    logic             cstream;
    logic [BDI_W-1:0] bdi;
    logic             rcy1;
    logic             rcy0;
    logic [PORT_W-1:0] port1;
    logic [PORT_W-1:0] port0;
    logic [VPI_W-1:0] vpi1;
    logic [VPI_W-1:0] vpi0;
    logic [VCI_W-1:0] vci1;
    logic [VCI_W-1:0] vci0;
  } route_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_IDLE  = 2'd1,
    ERR_RCY   = 2'd2,
    ERR_RANGE = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    HOP_READ  = 2'd0,
    HOP_WRITE = 2'd1,
    HOP_BOUND = 2'd2
  } hop_e;

  function automatic err_e usage_err(entry_t e, logic from_rcy);
    if (!e.busy)                    return ERR_IDLE;
    else if (e.rcy_only && !from_rcy) return ERR_RCY;
    else                            return ERR_NONE;
  endfunction

  function automatic route_t to_route(entry_t e);
    route_t r;
    r.set_clp = e.set_clp;
    r.updisc  = e.updisc;
    r.cstream = e.cstream;
    r.bdi     = e.bdi;
    r.rcy1    = e.rcy1;
    r.rcy0    = e.rcy0;
    r.port1   = e.port1;
    r.port0   = e.port0;
    r.vpi1    = e.vpi1;
    r.vpi0    = e.vpi0;
    r.vci1    = e.vci1;
    r.vci0    = e.vci0;
    return r;
  endfunction
endpackage

// File: rtl/vxlt_ram.sv
module vxlt_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/vxlt_seq.sv
module vxlt_seq
  import vxlt_pkg::*;
#(
  parameter int ENTRIES   = 1024,
  parameter int CNT_W     = 32,
  parameter int DEF_BOUND = 256,
  localparam int AW       = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPI_W-1:0]   req_vpi,
  input  logic [VCI_W-1:0]   req_vci,
  input  logic               req_clp,
  input  logic               req_from_rcy,
  input  logic [PORT_W-1:0]  req_stg,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic [1:0]         host_op,
  input  logic [AW-1:0]      host_addr,
  input  logic [ENTRY_W-1:0] host_wentry,
  input  logic [CNT_W-1:0]   host_wcnt,
  output logic               host_rvalid,
  output logic [ENTRY_W-1:0] host_rentry,
  output logic [CNT_W-1:0]   host_rcnt,
  output logic [AW-1:0]      mem_addr,
  output logic               tbl_we,
  output logic [ENTRY_W-1:0] tbl_wdata,
  input  logic [ENTRY_W-1:0] tbl_rdata,
  output logic               cnt_we,
  output logic [CNT_W-1:0]   cnt_wdata,
  input  logic [CNT_W-1:0]   cnt_rdata,
  output logic               done,
  output route_t             sel_route,
  output err_e               sel_err,
  output logic               hdr_clp,
  output logic               hdr_rcy,
  output logic [PORT_W-1:0]  hdr_stg
);
  localparam int SW = ((VCI_W > AW) ? VCI_W : ((VPI_W > AW) ? VPI_W : AW)) + 2;

  typedef enum logic [2:0] {S_IDLE, S_VP, S_VC, S_PAD, S_DONE, S_HRD} st_e;
  st_e st_q, st_d;

  logic [AW-1:0]    bound_q, sel_addr_q;
  logic [VPI_W-1:0] vpi_q;
  logic [VCI_W-1:0] vci_q;
  logic [CNT_W-1:0] selcnt_q;
  logic [SW-1:0]    vc_sum;
  logic             vc_oor, vp_oor, req_fire, host_fire;
  entry_t           rd_e;

  assign rd_e      = entry_t'(tbl_rdata);
  assign vc_sum    = SW'(bound_q) + SW'(vci_q);
  assign vc_oor    = vc_sum > SW'(ENTRIES - 1);
  assign vp_oor    = SW'(vpi_q) >= SW'(bound_q);
  assign req_ready = (st_q == S_IDLE);
  assign host_ready = req_ready && !req_valid;
  assign req_fire  = req_ready && req_valid;
  assign host_fire = host_ready && host_valid;
  assign done      = (st_q == S_DONE);

  always_comb begin
    case (st_q)
      S_IDLE:  mem_addr = req_valid ? AW'(req_vpi) : host_addr;
      S_VP:    mem_addr = AW'(vc_sum);
      default: mem_addr = sel_addr_q;
    endcase
  end

  assign tbl_we    = host_fire && (host_op == HOP_WRITE);
  assign tbl_wdata = host_wentry;
  assign cnt_we    = tbl_we || (done && sel_err == ERR_NONE);
  assign cnt_wdata = done ? selcnt_q + CNT_W'(1) : host_wcnt;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: begin
        if (req_valid) st_d = S_VP;
        else if (host_valid && host_op == HOP_READ) st_d = S_HRD;
      end
      S_VP:   st_d = (!vp_oor && rd_e.vp_term) ? S_VC : S_DONE;
      S_VC:   st_d = S_PAD;
      S_PAD:  st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      S_HRD:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      bound_q     <= AW'(DEF_BOUND);
      sel_err     <= ERR_NONE;
      host_rvalid <= 1'b0;
      host_rentry <= '0;
      host_rcnt   <= '0;
      sel_addr_q  <= '0;
    end else begin
      st_q        <= st_d;
      host_rvalid <= (st_q == S_HRD);
      if (host_fire && host_op == HOP_BOUND) bound_q <= host_addr;
      if (req_fire) begin
        vpi_q   <= req_vpi;
        vci_q   <= req_vci;
        hdr_clp <= req_clp;
        hdr_rcy <= req_from_rcy;
        hdr_stg <= req_stg;
      end
      case (st_q)
        S_VP: begin
          sel_addr_q <= (!vp_oor && rd_e.vp_term) ? AW'(vc_sum) : AW'(vpi_q);
          sel_route  <= to_route(rd_e);
          selcnt_q   <= cnt_rdata;
          if (vp_oor)            sel_err <= ERR_RANGE;
          else if (rd_e.vp_term) sel_err <= vc_oor ? ERR_RANGE : ERR_NONE;
          else                   sel_err <= usage_err(rd_e, hdr_rcy);
        end
        S_VC: begin
          sel_route <= to_route(rd_e);
          selcnt_q  <= cnt_rdata;
          if (sel_err == ERR_NONE) sel_err <= usage_err(rd_e, hdr_rcy);
        end
        S_HRD: begin
          host_rentry <= tbl_rdata;
          host_rcnt   <= cnt_rdata;
        end
        default: ;
      endcase
    end
  end

  // R2 / R3: an accepted header reaches either the result or the channel read two edges later
  a_r2_branch: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> ##1 (st_q == S_DONE || st_q == S_VC));
  // R3: the chained path takes two further padding steps before completing
  a_r3_tail: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_VC) |=> (st_q == S_PAD) ##1 (st_q == S_DONE));
  // R12: the bound never moves while a lookup is in flight
  a_r12_bound_stable: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_IDLE && st_q != S_HRD) |=> $stable(bound_q));
  // R11: no host access is taken while a lookup is in flight
  a_r11_lockout: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_VP || st_q == S_VC || st_q == S_PAD) |-> !tbl_we && !cnt_we);
endmodule

// File: rtl/vxlt_fmt.sv
module vxlt_fmt
  import vxlt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_id,
  input  logic              done,
  input  route_t            sel_route,
  input  err_e              sel_err,
  input  logic              hdr_clp,
  input  logic              hdr_rcy,
  input  logic [PORT_W-1:0] hdr_stg,
  output logic              res_valid,
  output logic              res_err,
  output logic [1:0]        res_err_code,
  output logic [PORT_W-1:0] res_port0,
  output logic [PORT_W-1:0] res_port1,
  output logic [VPI_W-1:0]  res_vpi0,
  output logic [VPI_W-1:0]  res_vpi1,
  output logic [VCI_W-1:0]  res_vci0,
  output logic [VCI_W-1:0]  res_vci1,
  output logic              res_rcy0,
  output logic              res_rcy1,
  output logic              res_clp,
  output logic [PORT_W-1:0] res_stg,
  output logic              res_updisc,
  output logic              res_cstream,
  output logic [BDI_W-1:0]  res_bdi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_err      <= 1'b0;
      res_err_code <= ERR_NONE;
      res_port0    <= '0;
      res_port1    <= '0;
      res_vpi0     <= '0;
      res_vpi1     <= '0;
      res_vci0     <= '0;
      res_vci1     <= '0;
      res_rcy0     <= 1'b0;
      res_rcy1     <= 1'b0;
      res_clp      <= 1'b0;
      res_stg      <= '0;
      res_updisc   <= 1'b0;
      res_cstream  <= 1'b0;
      res_bdi      <= '0;
    end else begin
      res_valid    <= done && (sel_err == ERR_NONE);
      res_err      <= done && (sel_err != ERR_NONE);
      res_err_code <= done ? sel_err : ERR_NONE;
      if (done) begin
        res_port0   <= sel_route.port0;
        res_port1   <= sel_route.port1;
        res_vpi0    <= sel_route.vpi0;
        res_vpi1    <= sel_route.vpi1;
        res_vci0    <= sel_route.vci0;
        res_vci1    <= sel_route.vci1;
        res_rcy0    <= sel_route.rcy0;
        res_rcy1    <= sel_route.rcy1;
        res_clp     <= hdr_clp | sel_route.set_clp;
        res_stg     <= hdr_rcy ? hdr_stg : port_id;
        res_updisc  <= sel_route.updisc;
        res_cstream <= sel_route.cstream;
        res_bdi     <= sel_route.bdi;
      end
    end
  end

  // R13: good and dropped pulses exclude each other
  a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_err));
  // R13: every result pulse lasts one cycle
  a_r13_pulse: assert property (@(posedge clk) disable iff (rst)
    (res_valid || res_err) |=> !(res_valid || res_err));
  // R7 / R8 / R9: a drop always carries a nonzero reason
  a_r7_code: assert property (@(posedge clk) disable iff (rst)
    res_err |-> (res_err_code != 2'd0));
  // R5: a forced loss-priority request always shows on the output
  a_r5_clp: assert property (@(posedge clk) disable iff (rst)
    (done && sel_err == ERR_NONE && sel_route.set_clp) |=> res_clp);
endmodule

// File: rtl/vxlt_lookup.sv
module vxlt_lookup
  import vxlt_pkg::*;
#(
  parameter int ENTRIES   = 1024,
  parameter int CNT_W     = 32,
  parameter int DEF_BOUND = 256,
  localparam int AW       = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PORT_W-1:0]  port_id,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPI_W-1:0]   req_vpi,
  input  logic [VCI_W-1:0]   req_vci,
  input  logic               req_clp,
  input  logic               req_from_rcy,
  input  logic [PORT_W-1:0]  req_stg,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic [1:0]         host_op,
  input  logic [AW-1:0]      host_addr,
  input  logic [ENTRY_W-1:0] host_wentry,
  input  logic [CNT_W-1:0]   host_wcnt,
  output logic               host_rvalid,
  output logic [ENTRY_W-1:0] host_rentry,
  output logic [CNT_W-1:0]   host_rcnt,
  output logic               res_valid,
  output logic               res_err,
  output logic [1:0]         res_err_code,
  output logic [PORT_W-1:0]  res_port0,
  output logic [PORT_W-1:0]  res_port1,
  output logic [VPI_W-1:0]   res_vpi0,
  output logic [VPI_W-1:0]   res_vpi1,
  output logic [VCI_W-1:0]   res_vci0,
  output logic [VCI_W-1:0]   res_vci1,
  output logic               res_rcy0,
  output logic               res_rcy1,
  output logic               res_clp,
  output logic [PORT_W-1:0]  res_stg,
  output logic               res_updisc,
  output logic               res_cstream,
  output logic [BDI_W-1:0]   res_bdi
);
  logic [AW-1:0]      mem_addr;
  logic               tbl_we, cnt_we, done, hdr_clp, hdr_rcy;
  logic [ENTRY_W-1:0] tbl_wdata, tbl_rdata;
  logic [CNT_W-1:0]   cnt_wdata, cnt_rdata;
  logic [PORT_W-1:0]  hdr_stg;
  route_t             sel_route;
  err_e               sel_err;

  vxlt_ram #(.W(ENTRY_W), .DEPTH(ENTRIES)) u_tbl (
    .clk(clk), .we(tbl_we), .addr(mem_addr), .wdata(tbl_wdata), .rdata(tbl_rdata));

  vxlt_ram #(.W(CNT_W), .DEPTH(ENTRIES)) u_cnt (
    .clk(clk), .we(cnt_we), .addr(mem_addr), .wdata(cnt_wdata), .rdata(cnt_rdata));

  vxlt_seq #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .DEF_BOUND(DEF_BOUND)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpi(req_vpi), .req_vci(req_vci),
    .req_clp(req_clp), .req_from_rcy(req_from_rcy), .req_stg(req_stg),
    .host_valid(host_valid), .host_ready(host_ready), .host_op(host_op),
    .host_addr(host_addr), .host_wentry(host_wentry), .host_wcnt(host_wcnt),
    .host_rvalid(host_rvalid), .host_rentry(host_rentry), .host_rcnt(host_rcnt),
    .mem_addr(mem_addr), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .done(done), .sel_route(sel_route), .sel_err(sel_err),
    .hdr_clp(hdr_clp), .hdr_rcy(hdr_rcy), .hdr_stg(hdr_stg));

  vxlt_fmt u_fmt (
    .clk(clk), .rst(rst), .port_id(port_id), .done(done),
    .sel_route(sel_route), .sel_err(sel_err),
    .hdr_clp(hdr_clp), .hdr_rcy(hdr_rcy), .hdr_stg(hdr_stg),
    .res_valid(res_valid), .res_err(res_err), .res_err_code(res_err_code),
    .res_port0(res_port0), .res_port1(res_port1), .res_vpi0(res_vpi0), .res_vpi1(res_vpi1),
    .res_vci0(res_vci0), .res_vci1(res_vci1), .res_rcy0(res_rcy0), .res_rcy1(res_rcy1),
    .res_clp(res_clp), .res_stg(res_stg), .res_updisc(res_updisc),
    .res_cstream(res_cstream), .res_bdi(res_bdi));

  // R1 / R11: the host is never offered the port while headers are refused
  a_r11_ready_order: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> req_ready && !req_valid);
endmodule

// File: tb/tb_vxlt_lookup.sv
module tb_vxlt_lookup;
  logic clk = 0;
  logic rst = 1;
  always #2 clk = ~clk;

  logic [5:0]  port_id = 6'd13;
  logic        req_valid = 0, req_clp = 0, req_from_rcy = 0;
  logic [7:0]  req_vpi = 0;
  logic [15:0] req_vci = 0;
  logic [5:0]  req_stg = 0;
  logic        host_valid = 0;
  logic [1:0]  host_op = 0;
  logic [9:0]  host_addr = 0;
  logic [71:0] host_wentry = 0;
  logic [31:0] host_wcnt = 0;
  logic        req_ready, host_ready, host_rvalid;
  logic [71:0] host_rentry;
  logic [31:0] host_rcnt;
  logic        res_valid, res_err, res_rcy0, res_rcy1, res_clp, res_updisc, res_cstream;
  logic [1:0]  res_err_code;
  logic [5:0]  res_port0, res_port1, res_stg;
  logic [7:0]  res_vpi0, res_vpi1;
  logic [15:0] res_vci0, res_vci1;
  logic [3:0]  res_bdi;

  vxlt_lookup dut (
    .clk(clk), .rst(rst), .port_id(port_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpi(req_vpi), .req_vci(req_vci),
    .req_clp(req_clp), .req_from_rcy(req_from_rcy), .req_stg(req_stg),
    .host_valid(host_valid), .host_ready(host_ready), .host_op(host_op),
    .host_addr(host_addr), .host_wentry(host_wentry), .host_wcnt(host_wcnt),
    .host_rvalid(host_rvalid), .host_rentry(host_rentry), .host_rcnt(host_rcnt),
    .res_valid(res_valid), .res_err(res_err), .res_err_code(res_err_code),
    .res_port0(res_port0), .res_port1(res_port1), .res_vpi0(res_vpi0), .res_vpi1(res_vpi1),
    .res_vci0(res_vci0), .res_vci1(res_vci1), .res_rcy0(res_rcy0), .res_rcy1(res_rcy1),
    .res_clp(res_clp), .res_stg(res_stg), .res_updisc(res_updisc),
    .res_cstream(res_cstream), .res_bdi(res_bdi));

  int checks = 0, errors = 0, lat = 0;
  bit finished = 0;
  logic [71:0] wd5;

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] mk(input logic busy, sclp, term, ronly, ud, cs,
                                     input logic [3:0] bdi, input logic r1, r0,
                                     input logic [5:0] p1, p0, input logic [7:0] v1, v0,
                                     input logic [15:0] c1, c0);
    return {busy, sclp, term, ronly, ud, cs, bdi, r1, r0, p1, p0, v1, v0, c1, c0};
  endfunction

  task automatic hwrite(input logic [9:0] a, input logic [71:0] e, input logic [31:0] c);
    @(negedge clk);
    host_valid = 1; host_op = 2'd1; host_addr = a; host_wentry = e; host_wcnt = c;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic hbound(input logic [9:0] b);
    @(negedge clk);
    host_valid = 1; host_op = 2'd2; host_addr = b;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic hread(input logic [9:0] a);
    int n;
    @(negedge clk);
    host_valid = 1; host_op = 2'd0; host_addr = a;
    @(negedge clk);
    host_valid = 0;
    n = 1;
    while (!host_rvalid && n < 8) begin @(negedge clk); n++; end
  endtask

  task automatic lookup(input logic [7:0] vpi, input logic [15:0] vci, input logic clp,
                        input logic rcy, input logic [5:0] stg);
    @(negedge clk);
    req_valid = 1; req_vpi = vpi; req_vci = vci; req_clp = clp;
    req_from_rcy = rcy; req_stg = stg;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!(res_valid || res_err) && lat < 12) begin @(negedge clk); lat++; end
    chk("R13 exclusive pulse", {71'd0, res_valid & res_err}, 72'd0);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 host_ready", host_ready, 1);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_err", res_err, 0);
    chk("R1 host_rvalid", host_rvalid, 0);
  endtask

  task automatic t_one_step;
    lookup(8'd5, 16'h0999, 0, 0, 6'd50);
    chk("R2 latency", lat, 3);
    chk("R2 valid", res_valid, 1);
    chk("R4 port0", res_port0, 7);
    chk("R4 port1", res_port1, 42);
    chk("R4 vpi0", res_vpi0, 8'h11);
    chk("R4 vpi1", res_vpi1, 8'h33);
    chk("R4 vci0", res_vci0, 16'h1234);
    chk("R4 vci1", res_vci1, 16'hBEEF);
    chk("R4 rcy", {res_rcy1, res_rcy0}, 2'b10);
    chk("R4 flags", {res_updisc, res_cstream, res_bdi}, {2'b10, 4'hA});
    chk("R5 clp passes 0", res_clp, 0);
    chk("R6 link stg", res_stg, 13);
    @(negedge clk);
    chk("R13 single pulse", res_valid, 0);
    lookup(8'd5, 16'h0001, 1, 0, 6'd0);
    chk("R5 clp passes 1", res_clp, 1);
  endtask

  task automatic t_set_clp;
    lookup(8'd6, 16'h0, 0, 0, 6'd0);
    chk("R5 forced clp", res_clp, 1);
    chk("R5 port0", res_port0, 3);
  endtask

  task automatic t_two_step;
    lookup(8'd0, 16'd100, 0, 0, 6'd0);
    chk("R3 latency", lat, 5);
    chk("R3 valid", res_valid, 1);
    chk("R3 port0", res_port0, 21);
    chk("R3 port1", res_port1, 20);
    chk("R3 vpi pair", {res_vpi1, res_vpi0}, 16'h4455);
    chk("R3 vci pair", {res_vci1, res_vci0}, 32'h0101_0202);
    chk("R3 flags", {res_rcy1, res_rcy0, res_updisc, res_cstream, res_bdi}, {4'b0101, 4'h5});
  endtask

  task automatic t_vc_edge;
    lookup(8'd0, 16'd767, 0, 0, 6'd0);
    chk("R9 last entry valid", res_valid, 1);
    chk("R9 last entry port", res_port0, 63);
    lookup(8'd0, 16'd768, 0, 0, 6'd0);
    chk("R9 past end err", res_err, 1);
    chk("R9 past end code", res_err_code, 3);
    chk("R9 past end latency", lat, 5);
    chk("R9 past end no valid", res_valid, 0);
  endtask

  task automatic t_idle_entry;
    lookup(8'd7, 16'd0, 0, 0, 6'd0);
    chk("R7 err", res_err, 1);
    chk("R7 code", res_err_code, 1);
    chk("R7 no valid", res_valid, 0);
    chk("R7 latency", lat, 3);
  endtask

  task automatic t_rcy_only;
    lookup(8'd8, 16'd0, 0, 0, 6'd0);
    chk("R8 link err", res_err, 1);
    chk("R8 link code", res_err_code, 2);
    lookup(8'd8, 16'd0, 0, 1, 6'd9);
    chk("R8 recycled valid", res_valid, 1);
    chk("R8 recycled port", res_port0, 9);
    chk("R6 recycled stg", res_stg, 9);
  endtask

  task automatic t_counters;
    lookup(8'd9, 16'd0, 0, 0, 6'd0);
    hread(10'd9);
    chk("R10 counter wraps", host_rcnt, 0);
    hread(10'd5);
    chk("R10 two cells", host_rcnt, 2);
    chk("R10 word readback", host_rentry, wd5);
    hread(10'd6);
    chk("R10 preset plus one", host_rcnt, 6);
    hread(10'd7);
    chk("R10 idle drop untouched", host_rcnt, 7);
    hread(10'd8);
    chk("R10 only good cell counted", host_rcnt, 1);
    hread(10'd356);
    chk("R10 channel entry counted", host_rcnt, 1);
    hread(10'd0);
    chk("R10 path entry not counted", host_rcnt, 0);
  endtask

  task automatic t_bound_move;
    hbound(10'd512);
    lookup(8'd0, 16'd100, 0, 0, 6'd0);
    chk("R12 new base used", res_port0, 33);
    chk("R12 latency", lat, 5);
    hbound(10'd4);
    lookup(8'd5, 16'd0, 0, 0, 6'd0);
    chk("R9 vpi at bound err", res_err_code, 3);
    chk("R9 vpi at bound latency", lat, 3);
    hbound(10'd256);
    lookup(8'd5, 16'd0, 0, 0, 6'd0);
    chk("R12 restored", res_valid, 1);
  endtask

  task automatic t_host_lockout;
    @(negedge clk);
    req_valid = 1; req_vpi = 8'd0; req_vci = 16'd100; req_from_rcy = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R11 req_ready busy", req_ready, 0);
    chk("R11 host_ready busy", host_ready, 0);
    repeat (3) @(negedge clk);
    chk("R11 host_ready mid", host_ready, 0);
    @(negedge clk);
    chk("R11 ready again", {req_ready, host_ready}, 2'b11);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    wd5 = mk(1,0,0,0,1,0,4'hA,1,0,6'd42,6'd7,8'h33,8'h11,16'hBEEF,16'h1234);
    hwrite(10'd5, wd5, 0);
    hwrite(10'd6, mk(1,1,0,0,0,0,0,0,0,0,6'd3,0,0,0,0), 32'd5);
    hwrite(10'd0, mk(1,0,1,0,0,0,0,0,0,0,0,0,0,0,0), 0);
    hwrite(10'd356, mk(1,0,0,0,0,1,4'h5,0,1,6'd20,6'd21,8'h44,8'h55,16'h0101,16'h0202), 0);
    hwrite(10'd1023, mk(1,0,0,0,0,0,0,0,0,0,6'd63,0,0,0,0), 0);
    hwrite(10'd7, mk(0,0,0,0,0,0,0,0,0,0,6'd2,0,0,0,0), 32'd7);
    hwrite(10'd8, mk(1,0,0,1,0,0,0,0,0,0,6'd9,0,0,0,0), 0);
    hwrite(10'd9, mk(1,0,0,0,0,0,0,0,0,0,6'd1,0,0,0,0), 32'hFFFF_FFFF);
    hwrite(10'd612, mk(1,0,0,0,0,0,0,0,0,0,6'd33,0,0,0,0), 0);
    t_one_step();
    t_set_clp();
    t_two_step();
    t_vc_edge();
    t_idle_entry();
    t_rcy_only();
    t_counters();
    t_bound_move();
    t_host_lockout();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule